// File: doc/BRIEF.md
# Receiver Gain Controller with Hold and Lock

This block decides whether the receiver's front-end amplifier runs at full gain or at reduced gain, based on an unsigned signal-strength code delivered once per clock. It drops to reduced gain as soon as the code reaches an upper threshold. Reduced gain pulls the code down by a large step on its own, so the block returns to full gain only after the code has stayed below a second, lower threshold for an unbroken number of clock cycles. The gap between the two thresholds gives the loop its hysteresis.

A power-enable input and a gain-control input set the operating mode. While power-enable is low, the controller sits at full gain with everything cleared. At power-up, a high gain-control input forces full gain and suspends regulation. A falling edge of the gain-control input then restarts regulation. A rising edge of the gain-control input while powered freezes the current gain until the input falls again. Both control inputs are asynchronous and pass through two-flop synchronizers. The threshold values and the hold length are parameters.

Top module: `agc_lock_ctrl`

## Requirements
- R1: While rst_ni is low, low_gain_o, locked_o and disabled_o are all 0.
- R2: In regulating mode at full gain, low_gain_o goes to 1 on the first rising edge that samples rssi_i >= TH_HI. A code of TH_HI-1 leaves it at 0.
- R3: In regulating mode at reduced gain, low_gain_o returns to 0 on the rising edge that samples the HOLD_CYC-th consecutive code below TH_LO. A code equal to TH_LO does not count as below.
- R4: Any sampled code >= TH_LO before the hold count completes restarts the count from zero.
- R5: A code between the thresholds (TH_LO <= code < TH_HI) leaves the gain unchanged in either gain state.
- R6: If ac_i is high when shdn_i rises, disabled_o becomes 1 on the third rising edge after the change. low_gain_o then stays 0 whatever the code.
- R7: From the disabled mode, a fall of ac_i while shdn_i is high clears disabled_o on the third rising edge, and regulation resumes on the edge after that.
- R8: A rise of ac_i while powered in regulating mode sets locked_o on the third rising edge and freezes low_gain_o at its current value. A fall of ac_i clears locked_o on the third edge, and regulation resumes on the edge after that.
- R9: Changes of ac_i while shdn_i is low have no effect. All outputs stay 0, and the mode on power-up depends only on the level of ac_i at that time.
- R10: When shdn_i goes low, all outputs are 0 from the third rising edge after the change, and the hold count is cleared.
- R11: locked_o and disabled_o are never 1 at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| shdn_i | input | 1 | Power enable, high = powered (asynchronous) |
| ac_i | input | 1 | Gain-control input selecting lock, disable or resume (asynchronous) |
| rssi_i | input | RSSI_W | Unsigned signal-strength code, synchronous to clk_i |
| low_gain_o | output | 1 | 1 = reduced amplifier gain |
| locked_o | output | 1 | 1 while the gain is frozen |
| disabled_o | output | 1 | 1 while full gain is forced |

## Verification
A code change takes effect on the first rising edge after it is applied. A change of shdn_i or ac_i passes through two synchronizer flops, so it reaches the mode register and the flags on the third rising edge. Where regulation resumes after an unlock or re-enable, the gain moves one edge later still. The bench drives every input on a falling edge and counts edges from that point. For each latency it checks the output after the edge just before the expected one, where the value must be unchanged, and again after the expected edge. For the hold time it checks one edge short of HOLD_CYC and again at HOLD_CYC.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_RUN  = 2'd1,
    MODE_LOCK = 2'd2,
    MODE_DIS  = 2'd3
  } agc_mode_e;
endpackage

// File: rtl/agc_sync.sv
module agc_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic ff1, ff2;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ff1 <= 1'b0;
        ff2 <= 1'b0;
      end else begin
        ff1 <= d_i[i];
        ff2 <= ff1;
      end
    end
    assign q_o[i] = ff2;
  end
endmodule

// File: rtl/agc_release_timer.sv
module agc_release_timer #(
  parameter int HOLD_CYC = 250000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic below_i,
  output logic expire_o
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign expire_o = arm_i && below_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!arm_i || !below_i || expire_o) cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/agc_gain_fsm.sv
module agc_gain_fsm
  import agc_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      en_i,
  input  logic      ac_i,
  input  logic      above_i,
  input  logic      expire_i,
  output agc_mode_e mode_o,
  output logic      low_gain_o,
  output logic      arm_o
);
  agc_mode_e mode_q, mode_d;
  logic      gain_q, gain_d;
  logic      ac_q;
  logic      ac_rise, ac_fall;

  assign ac_rise = ac_i && !ac_q;
  assign ac_fall = !ac_i && ac_q;

  always_comb begin
    mode_d = mode_q;
    gain_d = gain_q;
    if (!en_i) begin
      mode_d = MODE_OFF;
      gain_d = 1'b0;
    end else begin
      unique case (mode_q)
        MODE_OFF:  mode_d = ac_i ? MODE_DIS : MODE_RUN;
        MODE_RUN: begin
          if (ac_rise)                  mode_d = MODE_LOCK;
          else if (!gain_q && above_i)  gain_d = 1'b1;
          else if (gain_q && expire_i)  gain_d = 1'b0;
        end
        MODE_LOCK: if (ac_fall) mode_d = MODE_RUN;
        MODE_DIS: begin
          gain_d = 1'b0;
          if (ac_fall) mode_d = MODE_RUN;
        end
        default:   mode_d = MODE_OFF;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_OFF;
      gain_q <= 1'b0;
      ac_q   <= 1'b0;
    end else begin
      mode_q <= mode_d;
      gain_q <= gain_d;
      ac_q   <= ac_i;
    end
  end

  assign mode_o     = mode_q;
  assign low_gain_o = gain_q;
  assign arm_o      = (mode_q == MODE_RUN) && gain_q && !ac_rise;
endmodule

// File: rtl/agc_lock_ctrl.sv
module agc_lock_ctrl
  import agc_pkg::*;
#(
  parameter int              RSSI_W   = 8,
  parameter logic [RSSI_W-1:0] TH_HI  = 8'd200,
  parameter logic [RSSI_W-1:0] TH_LO  = 8'd140,
  parameter int              HOLD_CYC = 250000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shdn_i,
  input  logic              ac_i,
  input  logic [RSSI_W-1:0] rssi_i,
  output logic              low_gain_o,
  output logic              locked_o,
  output logic              disabled_o
);
  logic [1:0] sync_q;
  logic       en_s, ac_s;
  logic       above, below, arm, expire;
  agc_mode_e  mode;

  agc_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({ac_i, shdn_i}),
    .q_o    (sync_q)
  );
  assign en_s = sync_q[0];
  assign ac_s = sync_q[1];

  assign above = (rssi_i >= TH_HI);
  assign below = (rssi_i < TH_LO);

  agc_release_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .arm_i    (arm),
    .below_i  (below),
    .expire_o (expire)
  );

  agc_gain_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_s),
    .ac_i       (ac_s),
    .above_i    (above),
    .expire_i   (expire),
    .mode_o     (mode),
    .low_gain_o (low_gain_o),
    .arm_o      (arm)
  );

  assign locked_o   = (mode == MODE_LOCK);
  assign disabled_o = (mode == MODE_DIS);
endmodule

// File: rtl/agc_lock_ctrl_chk.sv
module agc_lock_ctrl_chk #(
  parameter int              RSSI_W = 8,
  parameter logic [RSSI_W-1:0] TH_HI = 8'd200,
  parameter logic [RSSI_W-1:0] TH_LO = 8'd140
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_s_i,
  input logic [RSSI_W-1:0] rssi_i,
  input logic              low_gain_o,
  input logic              locked_o,
  input logic              disabled_o
);
  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(locked_o && disabled_o));

  assert_dis_full_gain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    disabled_o |-> !low_gain_o);

  assert_lock_freeze_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (locked_o && $past(locked_o)) |-> $stable(low_gain_o));

  assert_off_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_s_i |=> (!low_gain_o && !locked_o && !disabled_o));

  assert_attack_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(low_gain_o) |-> ($past(rssi_i) >= TH_HI));

  assert_release_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(low_gain_o) |-> (!$past(en_s_i) || ($past(rssi_i) < TH_LO)));
endmodule

bind agc_lock_ctrl agc_lock_ctrl_chk #(
  .RSSI_W (RSSI_W),
  .TH_HI  (TH_HI),
  .TH_LO  (TH_LO)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .en_s_i     (en_s),
  .rssi_i     (rssi_i),
  .low_gain_o (low_gain_o),
  .locked_o   (locked_o),
  .disabled_o (disabled_o)
);

// File: tb/agc_lock_ctrl_test.sv
`timescale 1ns/1ps
module agc_lock_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       shdn = 1'b0;
  logic       ac = 1'b0;
  logic [7:0] rssi = 8'd0;
  logic       low_gain, locked, disabled;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  agc_lock_ctrl #(
    .RSSI_W(8), .TH_HI(8'd200), .TH_LO(8'd140), .HOLD_CYC(10)
  ) uut (
    .clk_i(clk), .rst_ni(rst_ni), .shdn_i(shdn), .ac_i(ac), .rssi_i(rssi),
    .low_gain_o(low_gain), .locked_o(locked), .disabled_o(disabled)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    #3;
    chk("R1", "low_gain", low_gain, 1'b0);
    chk("R1", "locked", locked, 1'b0);
    chk("R1", "disabled", disabled, 1'b0);
    @(negedge clk) rst_ni = 1'b1;
  endtask

  task automatic t_power_run;
    @(negedge clk) begin ac = 1'b0; shdn = 1'b1; rssi = 8'd199; end
    tick(3);
    chk("R6", "disabled after run power-up", disabled, 1'b0);
    chk("R11", "locked after power-up", locked, 1'b0);
  endtask

  task automatic t_attack;
    tick(2);
    chk("R2", "code TH_HI-1 keeps full gain", low_gain, 1'b0);
    @(negedge clk) rssi = 8'd200;
    tick(1);
    chk("R2", "code TH_HI selects low gain", low_gain, 1'b1);
  endtask

  task automatic t_hyst_release;
    @(negedge clk) rssi = 8'd150;
    tick(30);
    chk("R5", "band keeps low gain", low_gain, 1'b1);
    @(negedge clk) rssi = 8'd139;
    tick(9);
    chk("R3", "one short of hold", low_gain, 1'b1);
    tick(1);
    chk("R3", "release at hold", low_gain, 1'b0);
    @(negedge clk) rssi = 8'd150;
    tick(20);
    chk("R5", "band keeps full gain", low_gain, 1'b0);
  endtask

  task automatic t_restart;
    @(negedge clk) rssi = 8'd200;
    tick(1);
    chk("R2", "re-attack", low_gain, 1'b1);
    @(negedge clk) rssi = 8'd100;
    tick(5);
    @(negedge clk) rssi = 8'd140;
    tick(1);
    chk("R4", "code TH_LO not below", low_gain, 1'b1);
    @(negedge clk) rssi = 8'd100;
    tick(9);
    chk("R4", "count restarted", low_gain, 1'b1);
    tick(1);
    chk("R4", "release after full restart", low_gain, 1'b0);
  endtask

  task automatic t_lock_low;
    @(negedge clk) rssi = 8'd255;
    tick(1);
    @(negedge clk) ac = 1'b1;
    tick(2);
    chk("R8", "lock not before third edge", locked, 1'b0);
    tick(1);
    chk("R8", "locked at third edge", locked, 1'b1);
    @(negedge clk) rssi = 8'd0;
    tick(30);
    chk("R8", "low gain frozen", low_gain, 1'b1);
    chk("R11", "disabled while locked", disabled, 1'b0);
    @(negedge clk) ac = 1'b0;
    tick(3);
    chk("R8", "unlock at third edge", locked, 1'b0);
    tick(9);
    chk("R8", "hold restarts after unlock", low_gain, 1'b1);
    tick(1);
    chk("R8", "release after unlock", low_gain, 1'b0);
  endtask

  task automatic t_lock_high;
    @(negedge clk) ac = 1'b1;
    tick(3);
    chk("R8", "locked at full gain", locked, 1'b1);
    @(negedge clk) rssi = 8'd255;
    tick(20);
    chk("R8", "full gain frozen", low_gain, 1'b0);
    @(negedge clk) ac = 1'b0;
    tick(3);
    chk("R8", "unlocked", locked, 1'b0);
    chk("R8", "no switch on unlock edge", low_gain, 1'b0);
    tick(1);
    chk("R8", "attack resumes", low_gain, 1'b1);
  endtask

  task automatic t_shutdown;
    @(negedge clk) shdn = 1'b0;
    tick(2);
    chk("R10", "gain before third edge", low_gain, 1'b1);
    tick(1);
    chk("R10", "gain cleared", low_gain, 1'b0);
    @(negedge clk) ac = 1'b1;
    tick(4);
    @(negedge clk) ac = 1'b0;
    tick(4);
    @(negedge clk) ac = 1'b1;
    tick(4);
    chk("R9", "locked while off", locked, 1'b0);
    chk("R9", "disabled while off", disabled, 1'b0);
  endtask

  task automatic t_disable_resume;
    @(negedge clk) shdn = 1'b1;
    tick(3);
    chk("R6", "disabled on power-up", disabled, 1'b1);
    chk("R11", "locked with disabled", locked, 1'b0);
    tick(20);
    chk("R6", "strong code ignored", low_gain, 1'b0);
    @(negedge clk) ac = 1'b0;
    tick(2);
    chk("R7", "still disabled", disabled, 1'b1);
    tick(1);
    chk("R7", "re-enabled", disabled, 1'b0);
    tick(1);
    chk("R7", "attack after resume", low_gain, 1'b1);
  endtask

  task automatic t_off_toggle_low;
    @(negedge clk) shdn = 1'b0;
    tick(4);
    @(negedge clk) ac = 1'b1;
    tick(4);
    @(negedge clk) ac = 1'b0;
    tick(4);
    @(negedge clk) shdn = 1'b1;
    tick(3);
    chk("R9", "no disable from off toggles", disabled, 1'b0);
    chk("R9", "no lock from off toggles", locked, 1'b0);
    tick(1);
    chk("R9", "regulating after power-up", low_gain, 1'b1);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    t_reset();
    t_power_run();
    t_attack();
    t_hyst_release();
    t_restart();
    t_lock_low();
    t_lock_high();
    t_shutdown();
    t_disable_resume();
    t_off_toggle_low();
    done = 1'b1;
    finish_run();
  end

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule